// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets clocked logic read and write an external asynchronous static RAM that has an active-low chip select, an active-low output enable, an active-low write strobe and a shared three-state byte bus. The host side is a request/ready handshake: the host presents an address, write data and a write flag together with `req_valid`, and the controller takes the request on a clock edge where `req_ready` is high. Read results come back on `rsp_rdata` with a single-cycle `rsp_valid` pulse.

Every memory cycle is split into phases whose lengths are clock counts fixed at elaboration: address setup, write-strobe pulse and write hold for a write; access wait and bus turnaround for a read. The controller ends each write by raising the write strobe while the chip select stays low, holds write data across that edge, keeps the memory's outputs off for the whole write, and releases its own bus driver before any read so that the two sides never drive the bus together. The bus is split into `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`; the pad buffer sits outside the block.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1; a reset in the middle of a cycle returns all of these at the next edge.
- R2: A write holds `mem_ce_n` low for T_SETUP+T_PULSE+T_HOLD cycles; `mem_we_n` goes low after exactly T_SETUP of them, stays low exactly T_PULSE cycles and rises while `mem_ce_n` is still low; `mem_oe_n` stays 1 throughout, and the location ends up holding the write data.
- R3: The bus driver (`mem_dq_oe` = 1) is on in every cycle of a write from setup through hold, off in every other cycle, and `mem_dq_out` equals the accepted write data while it is on.
- R4: A read holds `mem_ce_n` and `mem_oe_n` low for exactly T_ACCESS cycles with `mem_we_n` at 1 and `mem_dq_oe` at 0.
- R5: Read data is sampled from `mem_dq_in` at the edge that ends the access wait and is presented on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the T_ACCESS-th cycle after acceptance counting from 0.
- R6: `req_ready` is low for the whole transaction: T_SETUP+T_PULSE+T_HOLD cycles for a write and T_ACCESS+T_TURN for a read; a request is taken only on an edge where `req_valid` and `req_ready` are both high.
- R7: After a read, `mem_ce_n` and `mem_oe_n` are 1 with the driver off for T_TURN cycles; the driver is never on while `mem_oe_n` is low, and it turns on no earlier than the T_TURN+2-th cycle counting the cycle `mem_oe_n` rises as the first.
- R8: `mem_addr` holds the accepted address for every cycle `mem_ce_n` is low; changes on `req_addr` and `req_wdata` after acceptance have no effect on that cycle.
- R9: Every one of the 2^AW locations (AW = 17 by default, data width 8) can be written and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DW | Read data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Data toward the memory bus |
| mem_dq_oe | output | 1 | Enable for the controller's bus driver |
| mem_dq_in | input | DW | Data from the memory bus |

## Verification
The two functions that can meet in one cycle are the release of the bus after a read and the start of driving it for the next write. The bench provokes this by issuing each write immediately after a read returns, so the new request is taken on the first idle edge, and it judges the result by counting the cycles between the output enable rising and the driver turning on, while a monitor flags any cycle where the driver and the memory's output enable are both active. The read-data pulse is judged in the same sweep, since it lands in the first turnaround cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RWAIT  = 3'd4,
        PH_RTURN  = 3'd5
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } strobe_t;

    function automatic strobe_t strobes_for(input phase_e ph);
        strobe_t s;
        s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
        case (ph)
            PH_WSETUP: s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b1};
            PH_WPULSE: s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drv: 1'b1};
            PH_WHOLD:  s = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b1};
            PH_RWAIT:  s = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drv: 1'b0};
            default:   s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
        endcase
        return s;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned CW = 2,
    parameter int unsigned LS = 1,
    parameter int unsigned LP = 1,
    parameter int unsigned LH = 1,
    parameter int unsigned LA = 1,
    parameter int unsigned LT = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    start_wr,
    output logic    idle,
    output logic    capture,
    output strobe_t strb
);
    localparam logic [CW-1:0] CNT_S = CW'(LS - 1);
    localparam logic [CW-1:0] CNT_P = CW'(LP - 1);
    localparam logic [CW-1:0] CNT_H = CW'(LH - 1);
    localparam logic [CW-1:0] CNT_A = CW'(LA - 1);
    localparam logic [CW-1:0] CNT_T = CW'(LT - 1);

    phase_e        ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_d;
    strobe_t       strb_q;
    logic          last;

    assign last = (cnt_q == '0);

    always_comb begin
        ph_d    = ph_q;
        cnt_d   = last ? cnt_q : cnt_q - 1'b1;
        capture = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                cnt_d = cnt_q;
                if (start) begin
                    ph_d  = start_wr ? PH_WSETUP : PH_RWAIT;
                    cnt_d = start_wr ? CNT_S : CNT_A;
                end
            end
            PH_WSETUP: if (last) begin ph_d = PH_WPULSE; cnt_d = CNT_P; end
            PH_WPULSE: if (last) begin ph_d = PH_WHOLD;  cnt_d = CNT_H; end
            PH_WHOLD:  if (last) begin ph_d = PH_IDLE; end
            PH_RWAIT:  if (last) begin ph_d = PH_RTURN; cnt_d = CNT_T; capture = 1'b1; end
            PH_RTURN:  if (last) begin ph_d = PH_IDLE; end
            default:   ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            strb_q <= strobes_for(PH_IDLE);
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            strb_q <= strobes_for(ph_d);
        end
    end

    assign idle = (ph_q == PH_IDLE);
    assign strb = strb_q;

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int unsigned AW = 17,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic          capture,
    input  logic [DW-1:0] bus_in,
    output logic [AW-1:0] addr_out,
    output logic [DW-1:0] wdata_out,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (load) begin
                addr_q  <= addr_in;
                wdata_q <= wdata_in;
            end
            if (capture) begin
                rdata_q <= bus_in;
            end
            rvalid_q <= capture;
        end
    end

    assign addr_out  = addr_q;
    assign wdata_out = wdata_q;
    assign rdata     = rdata_q;
    assign rvalid    = rvalid_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned AW       = 17,
    parameter int unsigned DW       = 8,
    parameter int unsigned T_SETUP  = 1,
    parameter int unsigned T_PULSE  = 1,
    parameter int unsigned T_HOLD   = 1,
    parameter int unsigned T_ACCESS = 1,
    parameter int unsigned T_TURN   = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int unsigned LS   = at_least_one(T_SETUP);
    localparam int unsigned LP   = at_least_one(T_PULSE);
    localparam int unsigned LH   = at_least_one(T_HOLD);
    localparam int unsigned LA   = at_least_one(T_ACCESS);
    localparam int unsigned LT   = at_least_one(T_TURN);
    localparam int unsigned MAXL = max2(max2(max2(LS, LP), max2(LH, LA)), LT);
    localparam int unsigned CW   = $clog2(MAXL + 1);

    logic    idle;
    logic    take;
    logic    capture;
    strobe_t strb;

    assign take = req_valid && idle;

    asram_seq #(
        .CW(CW), .LS(LS), .LP(LP), .LH(LH), .LA(LA), .LT(LT)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (take),
        .start_wr (req_write),
        .idle     (idle),
        .capture  (capture),
        .strb     (strb)
    );

    asram_dpath #(
        .AW(AW), .DW(DW)
    ) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .addr_in   (req_addr),
        .wdata_in  (req_wdata),
        .capture   (capture),
        .bus_in    (mem_dq_in),
        .addr_out  (mem_addr),
        .wdata_out (mem_dq_out),
        .rdata     (rsp_rdata),
        .rvalid    (rsp_valid)
    );

    assign req_ready = idle;
    assign mem_ce_n  = strb.ce_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;
    assign mem_dq_oe = strb.drv;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int unsigned AW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_dq_oe
);
    // R1: first cycle after reset is fully idle
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid));

    // R2: write strobe only inside chip select, with the driver on
    a_r2_we_in_ce: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));

    // R3: driver only during a selected cycle with memory outputs off
    a_r3_drive_in_write: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

    // R4: output enable only in a selected, non-writing cycle
    a_r4_read_strobes: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    // R5: read-data strobe lasts one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R6: ready only while the memory is deselected
    a_r6_ready_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && !mem_dq_oe));

    // R7: no write strobe or driver directly after output enable falls away
    a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> !mem_dq_oe);

    // R8: address stable while selected
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int TS = 1;
    localparam int TP = 2;
    localparam int TH = 1;
    localparam int TA = 2;
    localparam int TT = 2;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    logic [DW-1:0] model  [DEPTH];
    logic [DW-1:0] golden [DEPTH];

    int n_vec = 0;
    int n_bad = 0;
    int since_oe = 1000;
    bit prev_drv = 1'b0;
    int contention = 0;

    always #10 clk = ~clk;

    asram_ctrl #(
        .AW(AW), .DW(DW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH),
        .T_ACCESS(TA), .T_TURN(TT)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // memory model: drives data while selected for read, stores on write-strobe rise
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model[mem_addr] : '0;

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) model[mem_addr] <= mem_dq_out;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // R7 monitor: contention and turnaround gap
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && !mem_oe_n) contention++;
            if (!mem_oe_n) since_oe = 0;
            else if (since_oe < 1000) since_oe++;
            if (mem_dq_oe && !prev_drv)
                chk(since_oe >= TT + 2, "R7 driver-on gap after read", since_oe, TT + 2);
            prev_drv = mem_dq_oe;
        end
    end

    task automatic wait_ready();
        for (int i = 0; i < 64 && !req_ready; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int busy = 0, we_low = 0, first_we = -1, ce_low = 0, oe_low = 0;
        int drv = 0, bad_d = 0, bad_a = 0;
        wait_ready();
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        for (int idx = 0; idx < 64 && !req_ready; idx++) begin
            busy++;
            if (!mem_we_n) begin we_low++; if (first_we < 0) first_we = idx; end
            if (!mem_ce_n) begin ce_low++; if (mem_addr != a) bad_a++; end
            if (!mem_oe_n) oe_low++;
            if (mem_dq_oe) begin drv++; if (mem_dq_out != d) bad_d++; end
            @(negedge clk);
        end
        golden[a] = d;
        chk(busy == TS + TP + TH, "R6 write busy cycles", busy, TS + TP + TH);
        chk(we_low == TP, "R2 write strobe width", we_low, TP);
        chk(first_we == TS, "R2 write strobe start", first_we, TS);
        chk(ce_low == TS + TP + TH, "R2 chip select span", ce_low, TS + TP + TH);
        chk(oe_low == 0, "R2 output enable during write", oe_low, 0);
        chk(drv == TS + TP + TH, "R3 driver span", drv, TS + TP + TH);
        chk(bad_d == 0, "R3 write data stable", bad_d, 0);
        chk(bad_a == 0, "R8 address stable", bad_a, 0);
        chk(model[a] == d, "R9 location stored", int'(model[a]), int'(d));
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int busy = 0, oe_low = 0, ce_low = 0, we_low = 0, drv = 0;
        int pulses = 0, pulse_at = -1, got = -1, bad_a = 0, turn = 0;
        wait_ready();
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h5A;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        for (int idx = 0; idx < 64 && !req_ready; idx++) begin
            busy++;
            if (!mem_oe_n) oe_low++;
            if (!mem_ce_n) begin ce_low++; if (mem_addr != a) bad_a++; end
            else if (mem_oe_n && !mem_dq_oe) turn++;
            if (!mem_we_n) we_low++;
            if (mem_dq_oe) drv++;
            if (rsp_valid) begin pulses++; pulse_at = idx; got = int'(rsp_rdata); end
            @(negedge clk);
        end
        chk(busy == TA + TT, "R6 read busy cycles", busy, TA + TT);
        chk(oe_low == TA, "R4 output enable span", oe_low, TA);
        chk(ce_low == TA, "R4 chip select span", ce_low, TA);
        chk(we_low == 0 && drv == 0, "R4 no strobe or driver", we_low + drv, 0);
        chk(pulses == 1, "R5 valid pulse count", pulses, 1);
        chk(pulse_at == TA, "R5 valid pulse cycle", pulse_at, TA);
        chk(got == int'(golden[a]), "R9 read data", got, int'(golden[a]));
        chk(turn == TT, "R7 turnaround cycles", turn, TT);
        chk(bad_a == 0, "R8 read address stable", bad_a, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin model[i] = '0; golden[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        chk(req_ready && !rsp_valid, "R1 ready in reset", {req_ready, rsp_valid}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset",
            {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

        // R1: reset during a write pulse
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h33; req_wdata = 8'hC3;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!mem_we_n, "R1 setup reached pulse before reset", mem_we_n, 0);
        rst = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready,
            "R1 mid-cycle reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
        rst = 1'b0;
        @(negedge clk);

        // R9: exhaustive write then read
        for (int a = 0; a < DEPTH; a++) do_write(AW'(a), DW'((a * 29 + 7) & 255));
        for (int a = 0; a < DEPTH; a++) do_read(AW'(a));

        // R7: read immediately followed by write, second pattern
        for (int a = 0; a < DEPTH; a++) begin
            do_write(AW'(a), DW'(a ^ 8'hA5 ^ (a >> 3)));
            do_read(AW'(a));
        end
        for (int a = DEPTH - 1; a >= 0; a--) do_read(AW'(a));

        chk(contention == 0, "R7 contention cycles", contention, 0);
        summary();
        $finish;
    end

endmodule